// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Triggers

A memory-mapped general-purpose I/O block for up to 32 pins on a simple 32-bit register bus with word-aligned offsets. Each pin has an output value and a direction. Input levels pass through a two-flop synchroniser before any logic sees them. The pin levels can be read back at any time through the level register.

Each pin can be set up to flag an event on a high level, a low level, a rising edge, a falling edge or both edges. Three per-pin registers encode the mode: trigger kind (edge or level), polarity, and a both-edges select. Detected events collect in a sticky status register. Software removes them by writing ones to a clear register. The pending view is status gated by a per-pin enable, and one interrupt output is the OR of all pending bits. A constant version register tells software whether both-edge detection is present.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every pin is an input (`pin_oe_o` all 0), all enables and status bits are 0, `irq_o` is low, and the version register reads 3.
- R2: A direction bit of 1 makes the pin an input (`pin_oe_o` bit 0). A 0 makes it an output (`pin_oe_o` bit 1). `pin_o` always shows the level register's written value.
- R3: Reading the level register (0x00) returns the written value for output pins. For input pins it returns the synchronised input, which reflects a change on `pin_i` only after two clock edges.
- R4: With the trigger-kind bit (0x18) at 0 the pin is level triggered. A polarity bit (0x1C) of 1 sets status while the synchronised input is high, and 0 sets it while the input is low.
- R5: With the trigger-kind bit at 1 and the both-edge bit (0x24) at 0, polarity 1 flags rising edges and polarity 0 flags falling edges. An edge is a difference between the synchronised input and its value one clock earlier.
- R6: With both the trigger-kind bit and the both-edge bit at 1, the pin flags rising and falling edges and polarity has no effect. The both-edge register is present (readable and writable) when the version is 3 or more.
- R7: Writing 1 to a bit of the clear register (0x14) clears that status bit. Bits written 0 leave status unchanged. Status bits otherwise stay set until cleared.
- R8: When an edge event and a clear of the same pin fall in the same cycle, the status bit stays set.
- R9: A level-triggered pin whose level is still active is clear for exactly the one cycle after the clear write, then set again.
- R10: The pending register (0x10) reads status (0x0C) AND enable (0x08). `irq_o` is high exactly when some pending bit is 1.
- R11: Writes to the status, pending and version registers (0x0C, 0x10, 0x20) are ignored, and the clear register reads 0.
- R12: A read presents its data on `bus_rdata_o` one clock after the request. Accesses whose address bits [1:0] are not zero are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after request |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| pin_o | output | NUM_PINS | Output values |
| pin_oe_o | output | NUM_PINS | Output enable per pin |
| irq_o | output | 1 | Combined interrupt |

## Verification
Checked on every cycle by assertions:
- A clear without a concurrent event empties the bit.
- Status bits never drop except by clear.
- A same-cycle edge event overrides a clear.
- The version read returns the constant.

Only the bench scenarios can show the following:
- Each trigger mode produces the right events for a given pin transition, which is tested with random mode mixes and random before/after pin patterns.
- The two-cycle synchroniser latency.
- The one-cycle dip of a still-active level pin after a clear.
- Writes to read-only registers being ignored.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned DATA_W = 32;

  // byte offsets; software depends on these
  localparam logic [7:0] OFF_LEVEL  = 8'h00;
  localparam logic [7:0] OFF_DIR    = 8'h04;
  localparam logic [7:0] OFF_EN     = 8'h08;
  localparam logic [7:0] OFF_STAT   = 8'h0C;
  localparam logic [7:0] OFF_PEND   = 8'h10;
  localparam logic [7:0] OFF_CLR    = 8'h14;
  localparam logic [7:0] OFF_KIND   = 8'h18;
  localparam logic [7:0] OFF_POL    = 8'h1C;
  localparam logic [7:0] OFF_VER    = 8'h20;
  localparam logic [7:0] OFF_BOTH   = 8'h24;

  localparam int unsigned BOTH_MIN_VERSION = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_i[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign sync_o[i] = sync_q;
    assign prev_o[i] = prev_q;
  end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] prev_i,
  input  logic [N-1:0] kind_i,   // 1 edge, 0 level
  input  logic [N-1:0] pol_i,    // 1 high/rising, 0 low/falling
  input  logic [N-1:0] both_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] evt;
  logic [N-1:0] status_q;

  for (genvar i = 0; i < N; i++) begin : g_evt
    logic rise, fall;
    assign rise = sync_i[i] & ~prev_i[i];
    assign fall = ~sync_i[i] & prev_i[i];
    always_comb begin
      if (!kind_i[i])      evt[i] = pol_i[i] ? sync_i[i] : ~sync_i[i];
      else if (both_i[i])  evt[i] = rise | fall;
      else                 evt[i] = pol_i[i] ? rise : fall;
    end
  end

  // edge events override a clear; level events lose it for one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | (evt & (kind_i | ~clr_i));
  end

  assign status_o = status_q;

  a_r7_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(clr_i & ~evt)) == '0));

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~status_q & $past(status_q & ~clr_i)) == '0));

  a_r8_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(evt & kind_i)) == $past(evt & kind_i)));
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N       = 32,
  parameter int unsigned VERSION = 3,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N-1:0]      sync_i,
  input  logic [N-1:0]      status_i,
  output logic [N-1:0]      val_o,
  output logic [N-1:0]      dir_o,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      kind_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      both_o,
  output logic [N-1:0]      clr_o
);
  localparam logic [DATA_W-1:0] VER_WORD = DATA_W'(VERSION);

  function automatic logic [DATA_W-1:0] pad(input logic [N-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[N-1:0] = v;
    return r;
  endfunction

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  logic aligned, wr, rd;
  logic [N-1:0] wbits;
  logic [N-1:0] val_q, dir_q, en_q, kind_q, pol_q, both_q;
  logic [DATA_W-1:0] rd_mux;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = req_i & we_i & aligned;
  assign rd      = req_i & ~we_i & aligned;
  assign wbits   = wdata_i[N-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      dir_q  <= '1;
      en_q   <= '0;
      kind_q <= '0;
      pol_q  <= '0;
    end else if (wr) begin
      if (hit(addr_i, OFF_LEVEL)) val_q  <= wbits;
      if (hit(addr_i, OFF_DIR))   dir_q  <= wbits;
      if (hit(addr_i, OFF_EN))    en_q   <= wbits;
      if (hit(addr_i, OFF_KIND))  kind_q <= wbits;
      if (hit(addr_i, OFF_POL))   pol_q  <= wbits;
    end
  end

  if (VERSION >= BOTH_MIN_VERSION) begin : g_both
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         both_q <= '0;
      else if (wr && hit(addr_i, OFF_BOTH)) both_q <= wbits;
    end
  end else begin : g_no_both
    assign both_q = '0;
  end

  assign clr_o = (wr && hit(addr_i, OFF_CLR)) ? wbits : '0;

  always_comb begin
    rd_mux = '0;
    if (hit(addr_i, OFF_LEVEL)) rd_mux = pad((dir_q & sync_i) | (~dir_q & val_q));
    if (hit(addr_i, OFF_DIR))   rd_mux = pad(dir_q);
    if (hit(addr_i, OFF_EN))    rd_mux = pad(en_q);
    if (hit(addr_i, OFF_STAT))  rd_mux = pad(status_i);
    if (hit(addr_i, OFF_PEND))  rd_mux = pad(status_i & en_q);
    if (hit(addr_i, OFF_KIND))  rd_mux = pad(kind_q);
    if (hit(addr_i, OFF_POL))   rd_mux = pad(pol_q);
    if (hit(addr_i, OFF_VER))   rd_mux = VER_WORD;
    if (hit(addr_i, OFF_BOTH))  rd_mux = pad(both_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end

  assign val_o  = val_q;
  assign dir_o  = dir_q;
  assign en_o   = en_q;
  assign kind_o = kind_q;
  assign pol_o  = pol_q;
  assign both_o = both_q & kind_q;

  a_r11_version_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit(addr_i, OFF_VER)) |=> (rdata_o == VER_WORD));

  a_r11_clr_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit(addr_i, OFF_CLR)) |=> (rdata_o == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned VERSION  = 3,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] sync, prev, status;
  logic [NUM_PINS-1:0] val, dir, en, kind, pol, both, clr;

  gpio_sync #(.N(NUM_PINS)) u_sync (
    .clk_i, .rst_ni, .pin_i, .sync_o(sync), .prev_o(prev)
  );

  gpio_evt_status #(.N(NUM_PINS)) u_evt (
    .clk_i, .rst_ni,
    .sync_i(sync), .prev_i(prev),
    .kind_i(kind), .pol_i(pol), .both_i(both), .clr_i(clr),
    .status_o(status)
  );

  gpio_irq_regs #(.N(NUM_PINS), .VERSION(VERSION), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .sync_i(sync), .status_i(status),
    .val_o(val), .dir_o(dir), .en_o(en), .kind_o(kind), .pol_o(pol),
    .both_o(both), .clr_o(clr)
  );

  assign pin_o    = val;
  assign pin_oe_o = ~dir;
  assign irq_o    = |(status & en);

  a_r10_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o);
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pins = '0;
  logic [N-1:0] pout, poe;
  logic        irq;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pins), .pin_o(pout), .pin_oe_o(poe), .irq_o(irq)
  );

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    tick(1);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    tick(1);
    req = 1'b0;
    d = rdata;
  endtask

  function automatic logic [31:0] exp_stat(input logic [31:0] o, input logic [31:0] n,
      input logic [31:0] k, input logic [31:0] p, input logic [31:0] b);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (!k[i])     r[i] = p[i] ? (o[i] | n[i]) : (~o[i] | ~n[i]);
      else if (b[i]) r[i] = o[i] ^ n[i];
      else           r[i] = p[i] ? (~o[i] & n[i]) : (o[i] & ~n[i]);
    end
    return r;
  endfunction

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, d2, k, p, b, e, o, n, exp;
    void'($urandom(32'd2024));
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    check("R1 oe", poe, 32'h0);
    check("R1 irq", irq, 1'b0);
    rd(6'h08, d); check("R1 enable", d, 32'h0);
    rd(6'h04, d); check("R1 dir", d, 32'hFFFF_FFFF);
    rd(6'h20, d); check("R1 version", d, 32'd3);

    // R2 direction and output drive
    wr(6'h04, 32'h0000_FFFF);
    wr(6'h00, 32'hA5C3_5A3C);
    check("R2 oe", poe, 32'hFFFF_0000);
    check("R2 pout", pout, 32'hA5C3_5A3C);
    pins = 32'h1234_9876;
    tick(3);
    rd(6'h00, d); check("R3 mixed read", d, 32'hA5C3_9876);

    // R3 synchroniser latency
    wr(6'h04, 32'hFFFF_FFFF);
    pins = 32'h0;
    tick(3);
    pins = 32'h0000_00F0;
    rd(6'h00, d); check("R3 old level", d, 32'h0);
    tick(2);
    rd(6'h00, d); check("R3 new level", d, 32'h0000_00F0);

    // R12 misaligned write ignored
    wr(6'h09, 32'hFFFF_FFFF);
    rd(6'h08, d); check("R12 misaligned", d, 32'h0);

    // R4 R5 R6 R10 random mode mixes
    for (int it = 0; it < 30; it++) begin
      k = $urandom; p = $urandom; b = $urandom; e = $urandom;
      o = $urandom; n = $urandom;
      if (it < 3) begin k = '0; end
      if (it == 3) begin k = '1; b = '0; end
      if (it == 4) begin k = '1; b = '1; end
      wr(6'h18, k); wr(6'h1C, p); wr(6'h24, b); wr(6'h08, e);
      pins = o;
      tick(5);
      wr(6'h14, 32'hFFFF_FFFF);
      tick(1);
      pins = n;
      tick(5);
      exp = exp_stat(o, n, k, p, b);
      rd(6'h0C, d);
      check(k == '0 ? "R4 level status" : (b == '1 ? "R6 both status" : "R5 edge status"), d, exp);
      rd(6'h10, d); check("R10 pending", d, exp & e);
      check("R10 irq", irq, |(exp & e));
    end
    rd(6'h24, d); check("R6 both readback", d, b);

    // R7 clear with zero, then with ones
    wr(6'h18, 32'h0); wr(6'h1C, 32'h0); wr(6'h24, 32'h0);
    pins = 32'h0000_FFFF;
    tick(4);
    wr(6'h18, 32'hFFFF_FFFF); wr(6'h1C, 32'hFFFF_FFFF);
    tick(2);
    rd(6'h0C, d);
    wr(6'h14, 32'h0);
    rd(6'h0C, d2); check("R7 zero clear no effect", d2, d);
    wr(6'h14, 32'h0000_00FF);
    rd(6'h0C, d2); check("R7 partial clear", d2, d & 32'hFFFF_FF00);

    // R11 read-only writes ignored
    rd(6'h0C, d);
    wr(6'h0C, ~d);
    rd(6'h0C, d2); check("R11 status write", d2, d);
    wr(6'h20, 32'h0);
    rd(6'h20, d); check("R11 version write", d, 32'd3);
    rd(6'h14, d); check("R11 clear reads 0", d, 32'h0);

    // R8 edge event and clear in same cycle: pin0 rising
    wr(6'h18, 32'h1); wr(6'h1C, 32'h1); wr(6'h24, 32'h0); wr(6'h08, 32'h1);
    pins = 32'h0;
    tick(4);
    wr(6'h14, 32'hFFFF_FFFF);
    rd(6'h0C, d); check("R7 cleared", d & 32'h1, 32'h0);
    pins = 32'h1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(6'h14, 32'h1);
    rd(6'h0C, d); check("R8 edge wins", d & 32'h1, 32'h1);
    check("R8 irq", irq, 1'b1);

    // R9 level pin dips one cycle after clear
    wr(6'h18, 32'h0); wr(6'h1C, 32'h2); wr(6'h08, 32'h2);
    pins = 32'h2;
    tick(4);
    check("R9 irq before", irq, 1'b1);
    wr(6'h14, 32'h2);
    check("R9 irq dip", irq, 1'b0);
    tick(1);
    check("R9 irq back", irq, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule